// File: doc/BRIEF.md
# Operand Hazard Interlock

This block sits at the issue stage of a short in-order pipeline (fetch, issue/address generation, execute, load completion) and decides whether the instruction waiting to issue must be held back. It keeps a short history of the producers that issued in the last few cycles. Each history slot holds up to two destination registers, each tagged with a producer class. The class fixes how late the value appears. The waiting instruction brings up to `NSRC` source registers, and each source is tagged with the stage that consumes it.

For every source that matches a recorded destination, the block finds the minimum issue distance. This distance depends on both the producer class and the consuming stage. The block then works out how many more cycles the consumer must wait, and takes the largest such value over all matches. `stall` is raised while that count is non-zero. An instruction issues in any cycle where `cand_valid` is high and `stall` is low, and only then is it recorded as a producer. A consumer held in place therefore sees its count fall by one each cycle. The forwarding paths and the datapath are outside this block.

A multi-word load enters the history once, when its final micro-op issues. It records the final word's register with one class and the register written by the next-to-last micro-op with another. A load that updates its base register records the loaded register and the new base in the same slot.

Top module: `ilk_interlock`

## Requirements
- R1: After reset the history is empty, so no candidate stalls until a producer has issued.
- R2: `stall` is high exactly when `cand_valid` is high and `stall_cnt` is non-zero; with `cand_valid` low, both `stall` and `stall_cnt` are 0.
- R3: Destination class code 1 (ALU, multiply, MAC, divide, double move, base-update address output) has an issue-side distance of 2. It has an execute-side distance of 1, which never stalls.
- R4: Destination class code 2 (loaded data) has an issue-side distance of 3 and an execute-side distance of 2.
- R5: Class code 3 (register written by the last micro-op of a multi-word load) has issue-side distance 3 and execute-side distance 2. Class code 4 (register written by the next-to-last micro-op) has distances 2 and 1.
- R6: Both destination fields of one slot are compared independently. A base-updating load uses code 2 for the data register and code 1 for the updated base, so a consumer of the base waits as for an ALU result.
- R7: Source need code 0 means the value is needed at issue, and code 1 means it is needed at execute. Codes 2 and 3 mean it is needed at execute of the second micro-op (store data of a register-offset store), which lowers the distance by one more cycle.
- R8: With age = cycles since the producer issued (1 for the cycle right after), the count for one match is distance minus age, floored at 0. `stall_cnt` is the maximum over all matches. A stalled candidate is not recorded, and a candidate held with unchanged sources sees the count drop by exactly one per cycle.
- R9: With `ZERO_HW` = 0 (default), register 0 is compared like any other register.
- R10: Destination class codes 0, 5, 6 and 7 and sources with their valid bit low never cause a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | An instruction is waiting to issue |
| cand_src_vld | input | NSRC | Per-source valid |
| cand_src_reg | input | NSRC*RW | Source register numbers, source k at bits k*RW |
| cand_src_need | input | NSRC*2 | Per-source need code (0 issue, 1 execute, 2/3 second micro-op execute) |
| cand_dst0_kind | input | 3 | Producer class of the first destination |
| cand_dst0_reg | input | RW | First destination register |
| cand_dst1_kind | input | 3 | Producer class of the second destination |
| cand_dst1_reg | input | RW | Second destination register |
| stall | output | 1 | Hold the candidate this cycle |
| stall_cnt | output | CW | Remaining cycles the candidate must wait |

## Verification
A corrupted history slot would show up as a wrong `stall_cnt` for a consumer of the affected register. It would also show up as a stall from a register that no recent producer wrote. A missed shift would appear as a count that does not fall while the candidate is held. Each slot ages out after `MAX_GAP`-1 cycles, so any such error appears at the ports within two cycles of the faulty update, and only while a matching consumer is waiting. The bench therefore pairs every producer class and need code with consumers at ages 1 and 2, and adds random traffic on a narrow register range so that matches are frequent.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
   localparam int KIND_W = 3;
   localparam int NEED_W = 2;

   typedef enum logic [KIND_W-1:0] {
      PK_NONE    = 3'd0,
      PK_EXEC    = 3'd1,
      PK_LOAD    = 3'd2,
      PK_MW_LAST = 3'd3,
      PK_MW_PREV = 3'd4
   } prod_kind_e;

   // cycles between the stage that reads a source and the issue stage
   function automatic int need_offset(input logic [NEED_W-1:0] n);
      case (n)
         2'd0:    return 0;
         2'd1:    return 1;
         default: return 2;
      endcase
   endfunction
endpackage

// File: rtl/ilk_history.sv
module ilk_history #(
   parameter int RW    = 5,
   parameter int DEPTH = 2,
   parameter int KW    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push,
   input  logic [KW-1:0]       in_kind0,
   input  logic [RW-1:0]       in_reg0,
   input  logic [KW-1:0]       in_kind1,
   input  logic [RW-1:0]       in_reg1,
   output logic [DEPTH*KW-1:0] h_kind0,
   output logic [DEPTH*RW-1:0] h_reg0,
   output logic [DEPTH*KW-1:0] h_kind1,
   output logic [DEPTH*RW-1:0] h_reg1
);
   logic [KW-1:0] k0_q [DEPTH];
   logic [KW-1:0] k1_q [DEPTH];
   logic [RW-1:0] r0_q [DEPTH];
   logic [RW-1:0] r1_q [DEPTH];

   // slot e holds the producer that issued e+1 cycles ago
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) begin
            k0_q[e] <= '0;
            k1_q[e] <= '0;
            r0_q[e] <= '0;
            r1_q[e] <= '0;
         end
      end else begin
         k0_q[0] <= push ? in_kind0 : '0;
         k1_q[0] <= push ? in_kind1 : '0;
         r0_q[0] <= push ? in_reg0  : '0;
         r1_q[0] <= push ? in_reg1  : '0;
         for (int e = 1; e < DEPTH; e++) begin
            k0_q[e] <= k0_q[e-1];
            k1_q[e] <= k1_q[e-1];
            r0_q[e] <= r0_q[e-1];
            r1_q[e] <= r1_q[e-1];
         end
      end
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_flat
      assign h_kind0[e*KW +: KW] = k0_q[e];
      assign h_kind1[e*KW +: KW] = k1_q[e];
      assign h_reg0[e*RW +: RW]  = r0_q[e];
      assign h_reg1[e*RW +: RW]  = r1_q[e];
   end
endmodule

// File: rtl/ilk_compare.sv
module ilk_compare #(
   parameter int RW          = 5,
   parameter int NSRC        = 3,
   parameter int DEPTH       = 2,
   parameter int KW          = 3,
   parameter int CW          = 2,
   parameter int GAP_EXEC    = 2,
   parameter int GAP_LOAD    = 3,
   parameter int GAP_MW_LAST = 3,
   parameter int GAP_MW_PREV = 2,
   parameter bit ZERO_HW     = 1'b0
) (
   input  logic [DEPTH*KW-1:0] h_kind0,
   input  logic [DEPTH*RW-1:0] h_reg0,
   input  logic [DEPTH*KW-1:0] h_kind1,
   input  logic [DEPTH*RW-1:0] h_reg1,
   input  logic [NSRC-1:0]     src_vld,
   input  logic [NSRC*RW-1:0]  src_reg,
   input  logic [NSRC*2-1:0]   src_need,
   output logic [CW-1:0]       need_cnt
);
   import ilk_pkg::*;

   localparam int NSLOT = 2;
   localparam int NCMP  = DEPTH * NSLOT * NSRC;

   // issue-side distance of each class; execute needs subtract from it
   function automatic int base_gap(input logic [KW-1:0] k);
      case (k)
         PK_EXEC:    return GAP_EXEC;
         PK_LOAD:    return GAP_LOAD;
         PK_MW_LAST: return GAP_MW_LAST;
         PK_MW_PREV: return GAP_MW_PREV;
         default:    return 0;
      endcase
   endfunction

   function automatic logic [CW-1:0] pair_need(
      input logic [KW-1:0] kd, input logic [RW-1:0] rd,
      input logic sv, input logic [RW-1:0] sr, input logic [1:0] sn,
      input int age);
      int g;
      g = base_gap(kd) - need_offset(sn) - age;
      if (!sv || rd != sr || g <= 0) return '0;
      if (ZERO_HW && sr == '0) return '0;
      return CW'(g);
   endfunction

   logic [CW-1:0] elem [NCMP];

   for (genvar e = 0; e < DEPTH; e++) begin : g_age
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         logic [KW-1:0] kd;
         logic [RW-1:0] rd;
         if (s == 0) begin : g_d0
            assign kd = h_kind0[e*KW +: KW];
            assign rd = h_reg0[e*RW +: RW];
         end else begin : g_d1
            assign kd = h_kind1[e*KW +: KW];
            assign rd = h_reg1[e*RW +: RW];
         end
         for (genvar k = 0; k < NSRC; k++) begin : g_src
            assign elem[(e*NSLOT + s)*NSRC + k] =
               pair_need(kd, rd, src_vld[k], src_reg[k*RW +: RW],
                         src_need[k*2 +: 2], e + 1);
         end
      end
   end

   always_comb begin
      need_cnt = '0;
      for (int i = 0; i < NCMP; i++) begin
         if (elem[i] > need_cnt) need_cnt = elem[i];
      end
   end
endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock #(
   parameter int RW          = 5,
   parameter int NSRC        = 3,
   parameter int GAP_EXEC    = 2,
   parameter int GAP_LOAD    = 3,
   parameter int GAP_MW_LAST = 3,
   parameter int GAP_MW_PREV = 2,
   parameter bit ZERO_HW     = 1'b0,
   localparam int MAX_GAP =
      (GAP_EXEC > GAP_LOAD ? GAP_EXEC : GAP_LOAD) > (GAP_MW_LAST > GAP_MW_PREV ? GAP_MW_LAST : GAP_MW_PREV)
      ? (GAP_EXEC > GAP_LOAD ? GAP_EXEC : GAP_LOAD)
      : (GAP_MW_LAST > GAP_MW_PREV ? GAP_MW_LAST : GAP_MW_PREV),
   localparam int CW = $clog2(MAX_GAP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cand_valid,
   input  logic [NSRC-1:0]   cand_src_vld,
   input  logic [NSRC*RW-1:0] cand_src_reg,
   input  logic [NSRC*2-1:0] cand_src_need,
   input  logic [2:0]        cand_dst0_kind,
   input  logic [RW-1:0]     cand_dst0_reg,
   input  logic [2:0]        cand_dst1_kind,
   input  logic [RW-1:0]     cand_dst1_reg,
   output logic              stall,
   output logic [CW-1:0]     stall_cnt
);
   localparam int KW    = ilk_pkg::KIND_W;
   localparam int DEPTH = MAX_GAP - 1;

   if (RW < 1 || NSRC < 1) begin : g_bad_size
      $error("ilk_interlock: RW and NSRC must be at least 1");
   end
   if (GAP_EXEC < 1 || GAP_LOAD < 1 || GAP_MW_LAST < 1 || GAP_MW_PREV < 1) begin : g_bad_gap
      $error("ilk_interlock: every class distance must be at least 1");
   end
   if (MAX_GAP < 2) begin : g_bad_depth
      $error("ilk_interlock: largest distance must be at least 2");
   end

   logic [DEPTH*KW-1:0] h_kind0, h_kind1;
   logic [DEPTH*RW-1:0] h_reg0, h_reg1;
   logic [CW-1:0]       need_cnt;
   logic                push;

   assign push      = cand_valid && (need_cnt == '0);
   assign stall     = cand_valid && (need_cnt != '0);
   assign stall_cnt = cand_valid ? need_cnt : '0;

   ilk_history #(.RW(RW), .DEPTH(DEPTH), .KW(KW)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .in_kind0 (cand_dst0_kind),
      .in_reg0  (cand_dst0_reg),
      .in_kind1 (cand_dst1_kind),
      .in_reg1  (cand_dst1_reg),
      .h_kind0  (h_kind0),
      .h_reg0   (h_reg0),
      .h_kind1  (h_kind1),
      .h_reg1   (h_reg1)
   );

   ilk_compare #(
      .RW(RW), .NSRC(NSRC), .DEPTH(DEPTH), .KW(KW), .CW(CW),
      .GAP_EXEC(GAP_EXEC), .GAP_LOAD(GAP_LOAD),
      .GAP_MW_LAST(GAP_MW_LAST), .GAP_MW_PREV(GAP_MW_PREV),
      .ZERO_HW(ZERO_HW)
   ) u_cmp (
      .h_kind0  (h_kind0),
      .h_reg0   (h_reg0),
      .h_kind1  (h_kind1),
      .h_reg1   (h_reg1),
      .src_vld  (cand_src_vld),
      .src_reg  (cand_src_reg),
      .src_need (cand_src_need),
      .need_cnt (need_cnt)
   );
endmodule

// File: rtl/ilk_checker.sv
module ilk_checker #(
   parameter int RW    = 5,
   parameter int NSRC  = 3,
   parameter int CW    = 2,
   parameter int DEPTH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cand_valid,
   input logic [NSRC-1:0]   cand_src_vld,
   input logic [NSRC*RW-1:0] cand_src_reg,
   input logic [NSRC*2-1:0] cand_src_need,
   input logic [2:0]        cand_dst0_kind,
   input logic [RW-1:0]     cand_dst0_reg,
   input logic [2:0]        cand_dst1_kind,
   input logic [RW-1:0]     cand_dst1_reg,
   input logic              stall,
   input logic [CW-1:0]     stall_cnt
);
   int idle_q;
   logic issued;
   assign issued = cand_valid && !stall;

   always_ff @(posedge clk) begin
      if (!rst_n)            idle_q <= DEPTH;
      else if (issued)       idle_q <= 0;
      else if (idle_q < DEPTH) idle_q <= idle_q + 1;
   end

   // R2: nothing waiting means no stall and a zero count
   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cand_valid |-> (!stall && stall_cnt == '0));

   // R10: a candidate with no valid source never waits
   assert_nosrc_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid && cand_src_vld == '0) |-> !stall);

   // R8: a held candidate counts down by one per cycle
   assert_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (!cand_valid || !$stable(cand_src_vld) || !$stable(cand_src_reg)
                 || !$stable(cand_src_need) || stall_cnt == $past(stall_cnt) - 1'b1));

   // R1, R8: once every recorded producer has aged out, no stall remains
   assert_aged_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_q >= DEPTH) |-> !stall);
endmodule

bind ilk_interlock ilk_checker #(.RW(RW), .NSRC(NSRC), .CW(CW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_ilk_interlock.sv
module sim_ilk_interlock;
   localparam int RW     = 5;
   localparam int NSRC   = 3;
   localparam int CW     = 2;
   localparam time PERIOD = 20ns;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cand_valid;
   logic [NSRC-1:0]   cand_src_vld;
   logic [NSRC*RW-1:0] cand_src_reg;
   logic [NSRC*2-1:0] cand_src_need;
   logic [2:0]        cand_dst0_kind, cand_dst1_kind;
   logic [RW-1:0]     cand_dst0_reg, cand_dst1_reg;
   logic              stall;
   logic [CW-1:0]     stall_cnt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   ilk_interlock #(.RW(RW), .NSRC(NSRC)) u0 (.*);

   // reference: issued producers with the cycle stamp of their issue edge
   int q_stamp[$];
   int q_k0[$], q_r0[$], q_k1[$], q_r1[$];
   int cyc = 0;

   function automatic int gap_of(int k);
      if (k == 1) return 2;
      if (k == 2) return 3;
      if (k == 3) return 3;
      if (k == 4) return 2;
      return 0;
   endfunction

   function automatic int model_cnt();
      int best = 0;
      if (!cand_valid) return 0;
      foreach (q_stamp[i]) begin
         int age = cyc - q_stamp[i];
         for (int k = 0; k < NSRC; k++) begin
            int sr = int'(cand_src_reg[k*RW +: RW]);
            int nd = int'(cand_src_need[k*2 +: 2]);
            int off = (nd == 0) ? 0 : (nd == 1) ? 1 : 2;
            if (!cand_src_vld[k]) continue;
            if (q_r0[i] == sr && gap_of(q_k0[i]) - off - age > best)
               best = gap_of(q_k0[i]) - off - age;
            if (q_r1[i] == sr && gap_of(q_k1[i]) - off - age > best)
               best = gap_of(q_k1[i]) - off - age;
         end
      end
      return best;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q_stamp.delete(); q_k0.delete(); q_r0.delete(); q_k1.delete(); q_r1.delete();
         cyc = 0;
      end else begin
         if (cand_valid && model_cnt() == 0) begin
            q_stamp.push_back(cyc);
            q_k0.push_back(int'(cand_dst0_kind)); q_r0.push_back(int'(cand_dst0_reg));
            q_k1.push_back(int'(cand_dst1_kind)); q_r1.push_back(int'(cand_dst1_reg));
         end
         cyc = cyc + 1;
         if (q_stamp.size() > 8) begin
            void'(q_stamp.pop_front()); void'(q_k0.pop_front()); void'(q_r0.pop_front());
            void'(q_k1.pop_front()); void'(q_r1.pop_front());
         end
      end
   end

   task automatic idle();
      cand_valid = 1'b0; cand_src_vld = '0; cand_src_reg = '0; cand_src_need = '0;
      cand_dst0_kind = '0; cand_dst0_reg = '0; cand_dst1_kind = '0; cand_dst1_reg = '0;
   endtask

   task automatic put(input int k0, input int r0, input int k1, input int r1,
                      input bit sv, input int sr, input int sn);
      idle();
      cand_valid = 1'b1;
      cand_dst0_kind = 3'(k0); cand_dst0_reg = RW'(r0);
      cand_dst1_kind = 3'(k1); cand_dst1_reg = RW'(r1);
      cand_src_vld[0] = sv; cand_src_reg[0 +: RW] = RW'(sr); cand_src_need[0 +: 2] = 2'(sn);
   endtask

   task automatic add_src(input int idx, input int sr, input int sn);
      cand_src_vld[idx] = 1'b1;
      cand_src_reg[idx*RW +: RW] = RW'(sr);
      cand_src_need[idx*2 +: 2] = 2'(sn);
   endtask

   // sample a quarter period after the driving edge, then move to the next one
   task automatic chk(input string tag, input int exp);
      int m;
      #(PERIOD/4);
      m = model_cnt();
      checks++;
      if (int'(stall_cnt) != m || stall != (m != 0)) begin
         errors++;
         $display("FAIL %s model: stall=%0b cnt=%0d expected stall=%0b cnt=%0d",
                  tag, stall, stall_cnt, (m != 0), m);
      end
      if (exp >= 0) begin
         checks++;
         if (int'(stall_cnt) != exp || stall != (exp != 0)) begin
            errors++;
            $display("FAIL %s: stall=%0b cnt=%0d expected stall=%0b cnt=%0d",
                     tag, stall, stall_cnt, (exp != 0), exp);
         end
      end
      @(negedge clk);
   endtask

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: empty history after reset
      put(0, 0, 0, 0, 1, 5, 0);             chk("R1", 0);
      idle();                                chk("R2", 0);

      // R3: ALU class
      put(1, 3, 0, 0, 0, 0, 0);             chk("R3", 0);
      put(0, 0, 0, 0, 1, 3, 0);             chk("R3", 1);
      chk("R8", 0);
      put(1, 4, 0, 0, 0, 0, 0);             chk("R3", 0);
      put(0, 0, 0, 0, 1, 4, 1);             chk("R3", 0);

      // R4: plain load
      put(2, 7, 0, 0, 0, 0, 0);             chk("R4", 0);
      put(0, 0, 0, 0, 1, 7, 0);             chk("R4", 2);
      chk("R8", 1);
      chk("R8", 0);
      put(2, 8, 0, 0, 0, 0, 0);             chk("R4", 0);
      put(0, 0, 0, 0, 1, 8, 1);             chk("R4", 1);
      chk("R8", 0);
      put(2, 9, 0, 0, 0, 0, 0);             chk("R4", 0);
      idle();                                chk("R2", 0);
      put(0, 0, 0, 0, 1, 9, 0);             chk("R8", 1);
      chk("R8", 0);

      // R5: multi-word load, last and next-to-last words
      put(3, 10, 4, 11, 0, 0, 0);           chk("R5", 0);
      put(0, 0, 0, 0, 1, 11, 0);            chk("R5", 1);
      chk("R5", 0);
      put(3, 10, 4, 11, 0, 0, 0);           chk("R5", 0);
      put(0, 0, 0, 0, 1, 10, 1);            chk("R5", 1);
      chk("R5", 0);
      put(3, 10, 4, 11, 0, 0, 0);           chk("R5", 0);
      put(0, 0, 0, 0, 1, 11, 1);            chk("R5", 0);
      put(3, 10, 4, 11, 0, 0, 0);           chk("R5", 0);
      put(0, 0, 0, 0, 1, 10, 0);            chk("R5", 2);
      chk("R5", 1);
      chk("R5", 0);

      // R6: base-updating load, base and data in one slot
      put(2, 12, 1, 13, 0, 0, 0);           chk("R6", 0);
      put(0, 0, 0, 0, 1, 13, 0);            chk("R6", 1);
      chk("R6", 0);
      put(2, 12, 1, 13, 0, 0, 0);           chk("R6", 0);
      put(0, 0, 0, 0, 1, 12, 0);            chk("R6", 2);
      chk("R6", 1);
      chk("R6", 0);

      // R7: second micro-op store data
      put(2, 14, 0, 0, 0, 0, 0);            chk("R7", 0);
      put(0, 0, 0, 0, 1, 14, 2);            chk("R7", 0);
      put(2, 14, 0, 0, 0, 0, 0);            chk("R7", 0);
      put(0, 0, 0, 0, 1, 14, 3);            chk("R7", 0);
      put(2, 14, 0, 0, 0, 0, 0);            chk("R7", 0);
      put(0, 0, 0, 0, 1, 14, 1);            chk("R7", 1);
      chk("R7", 0);

      // R8: maximum over several matches
      put(1, 15, 0, 0, 0, 0, 0);            chk("R8", 0);
      put(2, 16, 0, 0, 0, 0, 0);            chk("R8", 0);
      put(0, 0, 0, 0, 1, 15, 0); add_src(1, 16, 0); chk("R8", 2);
      chk("R8", 1);
      chk("R8", 0);
      put(2, 19, 0, 0, 0, 0, 0);            chk("R8", 0);
      put(1, 19, 0, 0, 0, 0, 0);            chk("R8", 0);
      put(0, 0, 0, 0, 1, 19, 0);            chk("R8", 1);
      chk("R8", 0);

      // R8: a stalled candidate leaves no record
      put(2, 22, 0, 0, 0, 0, 0);            chk("R8", 0);
      put(1, 24, 0, 0, 1, 22, 0);           chk("R8", 2);
      put(0, 0, 0, 0, 1, 24, 0);            chk("R8", 0);

      // R9: register 0 is compared
      put(1, 0, 0, 0, 0, 0, 0);             chk("R9", 0);
      put(0, 0, 0, 0, 1, 0, 0);             chk("R9", 1);
      chk("R9", 0);

      // R10: unused class codes and invalid sources
      put(5, 20, 7, 21, 0, 0, 0);           chk("R10", 0);
      put(0, 0, 0, 0, 1, 20, 0); add_src(2, 21, 0); chk("R10", 0);
      put(2, 21, 0, 0, 0, 0, 0);            chk("R10", 0);
      put(0, 0, 0, 0, 0, 21, 0);            chk("R10", 0);

      // random traffic on a narrow register range, compared with the model
      for (int n = 0; n < 600; n++) begin
         idle();
         cand_valid = ($urandom_range(0, 9) < 8);
         cand_dst0_kind = 3'($urandom_range(0, 7));
         cand_dst1_kind = 3'($urandom_range(0, 7));
         cand_dst0_reg = RW'($urandom_range(0, 3));
         cand_dst1_reg = RW'($urandom_range(0, 3));
         for (int k = 0; k < NSRC; k++) begin
            cand_src_vld[k] = $urandom_range(0, 1);
            cand_src_reg[k*RW +: RW] = RW'($urandom_range(0, 3));
            cand_src_need[k*2 +: 2] = 2'($urandom_range(0, 3));
         end
         chk("R8", -1);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule